// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Controller

This block holds the operand-forwarding and hazard logic for a four-stage RV32I integer pipeline. The stages are I (fetch, decode and control), Ex (register-file read and execute), Mem and WB. The register file is written in WB. The block is purely combinational. Each cycle it looks at the source registers of the instruction in Ex and at the destinations of the two older instructions in Mem and WB. From these it picks where each Ex operand comes from and decides whether the front of the pipeline must wait.

A result produced by a non-load instruction now in Mem is forwarded from the Ex/Mem register. A result two instructions old is forwarded from the Mem/WB register. The register file also bypasses a write and a read of the same register in one cycle, so the Mem/WB path can be removed by parameter. A load whose destination is needed by the very next instruction causes one stall cycle. During that cycle the PC and the I/Ex register hold, and the Ex/Mem register takes a bubble. On the next cycle the loaded value is forwarded from Mem/WB. Branches and jumps resolve in Ex. A taken outcome flushes the single younger instruction held in I by clearing the I/Ex register.

Top module: `hz4_pipe_ctl`

## Requirements
- R1: Operand select codes are 2'b00 register file, 2'b01 Ex/Mem register, 2'b10 Mem/WB register. The code 2'b11 is never produced. A used source register that matches the destination of a writing non-load in Mem selects 2'b01.
- R2: A used source register that matches only the destination of a writing instruction in WB selects 2'b10 (with the default FWD_FROM_WB=1).
- R3: When the instructions in both Mem and WB write the same matching register, the Mem (younger) value wins and the select is 2'b01.
- R4: A source index of 0 never forwards and never stalls, whatever the destinations are.
- R5: A source marked as not read by the Ex instruction never forwards and never stalls.
- R6: A load in Mem with a nonzero destination that matches a used Ex source causes a stall. During it pc_en=0, iex_en=0 and exmem_clr=1, and that operand's select is 2'b00.
- R7: On the cycle after a load-use stall, with the load now in WB and a bubble in Mem, the dependent operand selects 2'b10 and no stall is raised.
- R8: With no dependency and no redirect, pc_en=1, iex_en=1, iex_clr=0, exmem_clr=0 and both selects are 2'b00.
- R9: A taken branch or jump in Ex with no stall sets iex_clr=1, keeps pc_en=1 and leaves exmem_clr=0.
- R10: A redirect raised while a stall is active is ignored: iex_clr stays 0 and the stall outputs are unchanged.
- R11: A stage whose write enable is low never serves as a forwarding source and never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_idx | input | IDX_W | First source register index of the instruction in Ex |
| ex_rs2_idx | input | IDX_W | Second source register index of the instruction in Ex |
| ex_rs1_used | input | 1 | Ex instruction reads its first source |
| ex_rs2_used | input | 1 | Ex instruction reads its second source |
| mem_rd_idx | input | IDX_W | Destination index of the instruction in Mem |
| mem_wr_en | input | 1 | Instruction in Mem writes a register |
| mem_is_load | input | 1 | Instruction in Mem is a load |
| wb_rd_idx | input | IDX_W | Destination index of the instruction in WB |
| wb_wr_en | input | 1 | Instruction in WB writes a register |
| ex_redirect | input | 1 | Branch taken or jump resolved in Ex |
| fwd_a_sel | output | 2 | Source select for the first Ex operand |
| fwd_b_sel | output | 2 | Source select for the second Ex operand |
| pc_en | output | 1 | PC update enable |
| iex_en | output | 1 | I/Ex pipeline register load enable |
| iex_clr | output | 1 | I/Ex register clear (flush of the instruction in I) |
| exmem_clr | output | 1 | Ex/Mem register clear (bubble insertion) |

## Verification
The bound checker tests, on every evaluation, the rules that hold at any single instant. These are: the select code 2'b11 never appears, a zero or unread source never forwards, a stall always pairs held enables with a bubble, and a flush never coexists with a stall. Priority between the two forwarding sources, the exact source chosen for each pattern, and the two-cycle load-use sequence can only be shown by the bench. The bench applies dependency patterns and compares every output against values derived from the requirements.

// File: rtl/hz4_pkg.sv
package hz4_pkg;
   typedef enum logic [1:0] {
      SRC_RF    = 2'b00,
      SRC_EXMEM = 2'b01,
      SRC_MEMWB = 2'b10
   } src_sel_e;
endpackage

// File: rtl/hz4_fwd_pick.sv
// Selects the source of one Ex operand and flags a load-use conflict.
module hz4_fwd_pick
   import hz4_pkg::*;
#(
   parameter int IDX_W       = 5,
   parameter bit FWD_FROM_WB = 1'b1
) (
   input  logic [IDX_W-1:0] rs_idx,
   input  logic             rs_used,
   input  logic [IDX_W-1:0] mem_rd_idx,
   input  logic             mem_wr_en,
   input  logic             mem_is_load,
   input  logic [IDX_W-1:0] wb_rd_idx,
   input  logic             wb_wr_en,
   output src_sel_e         sel,
   output logic             ld_hit
);
   localparam logic [IDX_W-1:0] ZERO_IDX = '0;

   logic live_src;
   logic mem_match;
   logic wb_match;

   assign live_src  = rs_used && (rs_idx != ZERO_IDX);
   assign mem_match = live_src && mem_wr_en && (mem_rd_idx == rs_idx);
   assign ld_hit    = mem_match && mem_is_load;

   generate
      if (FWD_FROM_WB) begin : g_wb_path
         assign wb_match = live_src && wb_wr_en && (wb_rd_idx == rs_idx);
      end else begin : g_rf_bypass
         assign wb_match = 1'b0;
      end
   endgenerate

   always_comb begin
      if (mem_match) begin
         // younger producer wins; a load in Mem has no data yet
         sel = mem_is_load ? SRC_RF : SRC_EXMEM;
      end else if (wb_match) begin
         sel = SRC_MEMWB;
      end else begin
         sel = SRC_RF;
      end
   end
endmodule

// File: rtl/hz4_flow.sv
// Turns load-use conflicts and redirects into enables and clears.
module hz4_flow #(
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0] ld_hit,
   input  logic               redirect,
   output logic               pc_en,
   output logic               iex_en,
   output logic               iex_clr,
   output logic               exmem_clr
);
   logic stall;

   assign stall     = |ld_hit;
   assign pc_en     = !stall;
   assign iex_en    = !stall;
   assign exmem_clr = stall;
   // outcome of a stalled branch is computed from stale operands
   assign iex_clr   = redirect && !stall;
endmodule

// File: rtl/hz4_pipe_ctl.sv
module hz4_pipe_ctl
   import hz4_pkg::*;
#(
   parameter int IDX_W       = 5,
   parameter bit FWD_FROM_WB = 1'b1
) (
   input  logic [IDX_W-1:0] ex_rs1_idx,
   input  logic [IDX_W-1:0] ex_rs2_idx,
   input  logic             ex_rs1_used,
   input  logic             ex_rs2_used,
   input  logic [IDX_W-1:0] mem_rd_idx,
   input  logic             mem_wr_en,
   input  logic             mem_is_load,
   input  logic [IDX_W-1:0] wb_rd_idx,
   input  logic             wb_wr_en,
   input  logic             ex_redirect,
   output logic [1:0]       fwd_a_sel,
   output logic [1:0]       fwd_b_sel,
   output logic             pc_en,
   output logic             iex_en,
   output logic             iex_clr,
   output logic             exmem_clr
);
   localparam int NUM_SRC = 2;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_width
         $error("hz4_pipe_ctl: IDX_W out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0][IDX_W-1:0] src_idx;
   logic [NUM_SRC-1:0]            src_used;
   src_sel_e                      src_sel [NUM_SRC];
   logic [NUM_SRC-1:0]            ld_hit;

   assign src_idx  = {ex_rs2_idx, ex_rs1_idx};
   assign src_used = {ex_rs2_used, ex_rs1_used};

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         hz4_fwd_pick #(
            .IDX_W       (IDX_W),
            .FWD_FROM_WB (FWD_FROM_WB)
         ) u_pick (
            .rs_idx      (src_idx[g]),
            .rs_used     (src_used[g]),
            .mem_rd_idx  (mem_rd_idx),
            .mem_wr_en   (mem_wr_en),
            .mem_is_load (mem_is_load),
            .wb_rd_idx   (wb_rd_idx),
            .wb_wr_en    (wb_wr_en),
            .sel         (src_sel[g]),
            .ld_hit      (ld_hit[g])
         );
      end
   endgenerate

   assign fwd_a_sel = src_sel[0];
   assign fwd_b_sel = src_sel[1];

   hz4_flow #(
      .NUM_SRC (NUM_SRC)
   ) u_flow (
      .ld_hit    (ld_hit),
      .redirect  (ex_redirect),
      .pc_en     (pc_en),
      .iex_en    (iex_en),
      .iex_clr   (iex_clr),
      .exmem_clr (exmem_clr)
   );
endmodule

// File: rtl/hz4_pipe_ctl_chk.sv
module hz4_pipe_ctl_chk #(
   parameter int IDX_W = 5
) (
   input logic [IDX_W-1:0] ex_rs1_idx,
   input logic [IDX_W-1:0] ex_rs2_idx,
   input logic             ex_rs1_used,
   input logic             ex_rs2_used,
   input logic             ex_redirect,
   input logic [1:0]       fwd_a_sel,
   input logic [1:0]       fwd_b_sel,
   input logic             pc_en,
   input logic             iex_en,
   input logic             iex_clr,
   input logic             exmem_clr
);
   logic known;
   assign known = !$isunknown({ex_rs1_idx, ex_rs2_idx, ex_rs1_used, ex_rs2_used,
                               ex_redirect, fwd_a_sel, fwd_b_sel, pc_en, iex_en,
                               iex_clr, exmem_clr});

   always_comb begin
      if (known) begin
         p_no_code3_r1: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
            else $error("select code 3 produced");
         p_zero_src_r4: assert ((ex_rs1_idx != '0 || fwd_a_sel == 2'b00) &&
                                (ex_rs2_idx != '0 || fwd_b_sel == 2'b00))
            else $error("x0 source forwarded");
         p_unused_src_r5: assert ((ex_rs1_used || fwd_a_sel == 2'b00) &&
                                  (ex_rs2_used || fwd_b_sel == 2'b00))
            else $error("unread source forwarded");
         p_stall_bubble_r6: assert ((pc_en == iex_en) && (pc_en != exmem_clr))
            else $error("stall enables and bubble disagree");
         p_flush_no_stall_r10: assert (!iex_clr || (pc_en && ex_redirect))
            else $error("flush during stall or without redirect");
      end
   end
endmodule

bind hz4_pipe_ctl hz4_pipe_ctl_chk #(.IDX_W(IDX_W)) u_chk (
   .ex_rs1_idx  (ex_rs1_idx),
   .ex_rs2_idx  (ex_rs2_idx),
   .ex_rs1_used (ex_rs1_used),
   .ex_rs2_used (ex_rs2_used),
   .ex_redirect (ex_redirect),
   .fwd_a_sel   (fwd_a_sel),
   .fwd_b_sel   (fwd_b_sel),
   .pc_en       (pc_en),
   .iex_en      (iex_en),
   .iex_clr     (iex_clr),
   .exmem_clr   (exmem_clr)
);

// File: tb/sim_hz4_pipe_ctl.sv
module sim_hz4_pipe_ctl;
   localparam int IDX_W = 5;

   typedef struct packed {
      logic [7:0]       req;
      logic [IDX_W-1:0] rs1, rs2;
      logic             u1, u2;
      logic [IDX_W-1:0] mrd;
      logic             mwe, mld;
      logic [IDX_W-1:0] wrd;
      logic             wwe, red;
      logic [7:0]       expv; // {asel, bsel, pc_en, iex_en, iex_clr, exmem_clr}
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      // R8 independent operands
      '{8'd8,  5'd1, 5'd2, 1'b1, 1'b1, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 8'b00_00_1100},
      // R1 first operand from Ex/Mem
      '{8'd1,  5'd5, 5'd2, 1'b1, 1'b1, 5'd5, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 8'b01_00_1100},
      // R1 second operand from Ex/Mem
      '{8'd1,  5'd1, 5'd7, 1'b1, 1'b1, 5'd7, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_01_1100},
      // R2 second operand from Mem/WB
      '{8'd2,  5'd1, 5'd9, 1'b1, 1'b1, 5'd3, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0, 8'b00_10_1100},
      // R3 both stages match, younger wins
      '{8'd3,  5'd6, 5'd6, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 8'b01_01_1100},
      // R4 x0 sources with x0 destinations
      '{8'd4,  5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 8'b00_00_1100},
      // R4 load to x0 does not stall
      '{8'd4,  5'd0, 5'd3, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 8'b00_00_1100},
      // R5 unread sources matching a load
      '{8'd5,  5'd5, 5'd5, 1'b0, 1'b0, 5'd5, 1'b1, 1'b1, 5'd5, 1'b1, 1'b0, 8'b00_00_1100},
      // R5 unread second source only
      '{8'd5,  5'd3, 5'd4, 1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 8'b00_00_1100},
      // R6 load-use on first operand
      '{8'd6,  5'd8, 5'd2, 1'b1, 1'b1, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 8'b00_00_0001},
      // R6 load-use on second operand while WB also matches
      '{8'd6,  5'd2, 5'd8, 1'b1, 1'b1, 5'd8, 1'b1, 1'b1, 5'd8, 1'b1, 1'b0, 8'b00_00_0001},
      // R9 taken redirect flushes I
      '{8'd9,  5'd1, 5'd2, 1'b1, 1'b1, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b1, 8'b00_00_1110},
      // R10 redirect ignored under stall
      '{8'd10, 5'd8, 5'd2, 1'b1, 1'b1, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 8'b00_00_0001},
      // R11 write enables low everywhere
      '{8'd11, 5'd5, 5'd6, 1'b1, 1'b1, 5'd5, 1'b0, 1'b1, 5'd6, 1'b0, 1'b0, 8'b00_00_1100},
      // R11 Mem not writing, WB supplies
      '{8'd11, 5'd5, 5'd5, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0, 5'd5, 1'b1, 1'b0, 8'b10_10_1100}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [IDX_W-1:0] ex_rs1_idx, ex_rs2_idx, mem_rd_idx, wb_rd_idx;
   logic ex_rs1_used, ex_rs2_used, mem_wr_en, mem_is_load, wb_wr_en, ex_redirect;
   logic [1:0] fwd_a_sel, fwd_b_sel;
   logic pc_en, iex_en, iex_clr, exmem_clr;

   hz4_pipe_ctl #(.IDX_W(IDX_W)) u0 (
      .ex_rs1_idx  (ex_rs1_idx),
      .ex_rs2_idx  (ex_rs2_idx),
      .ex_rs1_used (ex_rs1_used),
      .ex_rs2_used (ex_rs2_used),
      .mem_rd_idx  (mem_rd_idx),
      .mem_wr_en   (mem_wr_en),
      .mem_is_load (mem_is_load),
      .wb_rd_idx   (wb_rd_idx),
      .wb_wr_en    (wb_wr_en),
      .ex_redirect (ex_redirect),
      .fwd_a_sel   (fwd_a_sel),
      .fwd_b_sel   (fwd_b_sel),
      .pc_en       (pc_en),
      .iex_en      (iex_en),
      .iex_clr     (iex_clr),
      .exmem_clr   (exmem_clr)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   task automatic check(input string tag, input logic [7:0] expv);
      logic [7:0] act;
      act = {fwd_a_sel, fwd_b_sel, pc_en, iex_en, iex_clr, exmem_clr};
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", tag, act, expv);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      ex_rs1_idx = v.rs1; ex_rs2_idx = v.rs2;
      ex_rs1_used = v.u1; ex_rs2_used = v.u2;
      mem_rd_idx = v.mrd; mem_wr_en = v.mwe; mem_is_load = v.mld;
      wb_rd_idx = v.wrd; wb_wr_en = v.wwe; ex_redirect = v.red;
      @(posedge clk);
      #1;
   endtask

   initial begin
      vec_t v;
      // idle pipeline: R8 quiet state
      v = '{8'd8, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 8'b00_00_1100};
      drive(v);
      check("R8 idle", v.expv);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].expv);
      end

      // R7: load x10 in Mem, dependent in Ex -> stall
      v = '{8'd7, 5'd10, 5'd3, 1'b1, 1'b1, 5'd10, 1'b1, 1'b1, 5'd2, 1'b1, 1'b0, 8'b00_00_0001};
      drive(v);
      check("R7 stall cycle", v.expv);
      // next cycle: bubble in Mem, load in WB
      v = '{8'd7, 5'd10, 5'd3, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd10, 1'b1, 1'b0, 8'b10_00_1100};
      drive(v);
      check("R7 after stall", v.expv);

      // R9 jump with both operands forwarded from Ex/Mem
      v = '{8'd9, 5'd12, 5'd12, 1'b1, 1'b1, 5'd12, 1'b1, 1'b0, 5'd12, 1'b1, 1'b1, 8'b01_01_1110};
      drive(v);
      check("R9 redirect with forwarding", v.expv);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      #3;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule